// File: doc/BRIEF.md
# Master-Mode Audio Serial Clock Generator

This block sits beside the serial port of an audio converter. After reset it reads three strap levels, one from the data pin and one from each of the two shared clock pins. From these it learns whether the port is clock master or clock slave, whether it runs at single or double speed, and which master-clock-to-frame ratio applies. The straps are read once, a fixed number of master-clock cycles after reset is released, and the values are held until the next reset.

As clock master, the block then turns both clock pins into outputs. From the master clock it drives a bit clock at 64 times the frame rate and a left/right frame clock. Both come from one position counter, so every frame-clock edge coincides with a bit-clock falling edge. As clock slave, the pins stay inputs for good and the generator stays idle. The pads and pull resistors are outside the block; it sees each pin as a read level plus a drive value and an output enable.

Top module: `audclk_master_gen`

## Requirements
- R1: While rst_n is low, cfg_valid, cfg_master, cfg_double, both output enables and both pin drive values are 0, and cfg_ratio is 0.
- R2: The straps are captured on the 1024th rising master-clock edge after rst_n goes high. cfg_valid is 0 before that edge and 1 from that edge until the next reset.
- R3: If dat_pin_in is 1 at capture, the role is master: cfg_master is 1 and frm_oe and bit_oe both become 1 on the capture edge. If it is 0, the role is slave: both enables stay 0, both drive values stay 0, and cfg_double and cfg_ratio read 0.
- R4: In master role, the frame-pin strap selects the speed: 0 gives single speed (cfg_double=0) and 1 gives double speed (cfg_double=1).
- R5: In master role, the bit-pin strap selects the base ratio: 0 gives 256 and 1 gives 384. Double speed halves it. cfg_ratio therefore reads 256 or 384 at single speed and 128 or 192 at double speed.
- R6: In master role, one bit-clock period lasts M = cfg_ratio/64 master-clock cycles. Each period is low for ceil(M/2) cycles and then high for floor(M/2) cycles. The first low phase starts with the capture edge.
- R7: In master role, the frame clock is low for the first 32 bit periods after capture and high for the next 32, repeating every 64 bit periods. It changes only on a cycle where the bit clock falls.
- R8: Changing any strap pin after capture has no effect on the configuration outputs, the enables or the generated waveforms until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_pin_in | input | 1 | Level read from the serial data pin (role strap) |
| frm_pin_in | input | 1 | Level read from the frame-clock pin (speed strap) |
| bit_pin_in | input | 1 | Level read from the bit-clock pin (ratio strap) |
| frm_out | output | 1 | Drive value for the frame-clock pin |
| frm_oe | output | 1 | Output enable for the frame-clock pin |
| bit_out | output | 1 | Drive value for the bit-clock pin |
| bit_oe | output | 1 | Output enable for the bit-clock pin |
| cfg_valid | output | 1 | Straps have been captured |
| cfg_master | output | 1 | Captured role is clock master |
| cfg_double | output | 1 | Captured speed is double speed |
| cfg_ratio | output | 10 | Master-clock cycles per frame in use |

## Verification
The bench checks the capture edge from both sides: one cycle before it cfg_valid must still be 0, and on it the value must be 1. A counter off by one, or one that latches early, fails at exactly that spot. For every combination of the two speed straps, it compares each cycle of two full frames against a computed waveform. This catches the odd 3-cycle bit period, where a wrong split of the low and high phases shows up, and a missing prescaler, which would double the bit rate at single speed. After capture, the bench toggles the strap pins at random and expects nothing to move. It also runs the slave role and expects both pins to stay undriven and quiet, which exposes a design that drives the clocks regardless of the data strap.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  typedef struct packed {
    role_e role;
    logic  dbl;
    logic  wide;
  } strap_t;

  localparam int unsigned FRAME_BITS = 64;

  function automatic logic [1:0] ticks_per_bit(input logic wide);
    return wide ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [9:0] ratio_of(input logic dbl, input logic wide);
    logic [9:0] base;
    base = wide ? 10'd384 : 10'd256;
    return dbl ? (base >> 1) : base;
  endfunction

endpackage

// File: rtl/audclk_strap.sv
module audclk_strap
  import audclk_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 1024
) (
  input  logic   clk_mst,
  input  logic   rst_n,
  input  logic   dat_pin_in,
  input  logic   frm_pin_in,
  input  logic   bit_pin_in,
  output strap_t cfg,
  output logic   done
);

  localparam int unsigned WW = $clog2(WAIT_CYCLES + 1);
  localparam logic [WW-1:0] LAST = WW'(WAIT_CYCLES - 1);

  logic [WW-1:0] wcnt;

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      done <= 1'b0;
      cfg  <= '{role: ROLE_SLAVE, dbl: 1'b0, wide: 1'b0};
    end else if (!done) begin
      if (wcnt == LAST) begin
        done     <= 1'b1;
        cfg.role <= dat_pin_in ? ROLE_MASTER : ROLE_SLAVE;
        cfg.dbl  <= frm_pin_in;
        cfg.wide <= bit_pin_in;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !done |-> (wcnt <= LAST)); // R2

  AST_CFG_HELD: assert property (@(posedge clk_mst) disable iff (!rst_n)
    done |=> (done && $stable(cfg))); // R8

endmodule

// File: rtl/audclk_prediv.sv
module audclk_prediv (
  input  logic clk_mst,
  input  logic rst_n,
  input  logic run,
  input  logic dbl,
  output logic tick,
  output logic pre
);

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) begin
      pre <= 1'b0;
    end else if (!run || dbl) begin
      pre <= 1'b0;
    end else begin
      pre <= ~pre;
    end
  end

  assign tick = run & (dbl | pre);

  AST_PRE_IDLE_DBL: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (run && dbl && $past(run && dbl)) |-> !pre); // R5

endmodule

// File: rtl/audclk_frame_ctr.sv
module audclk_frame_ctr
  import audclk_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = FRAME_BITS
) (
  input  logic clk_mst,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic pre,
  input  logic dbl,
  input  logic wide,
  output logic bit_clk,
  output logic frm_clk
);

  localparam int unsigned BW = $clog2(BITS_PER_FRAME);

  logic [1:0]    ph;
  logic [BW-1:0] bitcnt;
  logic [1:0]    nticks;
  logic [2:0]    per_bit;
  logic [2:0]    pos;
  logic [3:0]    pos2;

  assign nticks  = ticks_per_bit(wide);
  assign per_bit = dbl ? {1'b0, nticks} : {nticks, 1'b0};
  assign pos     = dbl ? {1'b0, ph} : {ph, pre};
  assign pos2    = {pos, 1'b0};

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      bitcnt <= '0;
    end else if (!run) begin
      ph     <= '0;
      bitcnt <= '0;
    end else if (tick) begin
      if (ph == nticks - 2'd1) begin
        ph     <= '0;
        bitcnt <= bitcnt + 1'b1;
      end else begin
        ph <= ph + 2'd1;
      end
    end
  end

  assign bit_clk = run & (pos2 >= {1'b0, per_bit});
  assign frm_clk = run & bitcnt[BW-1];

  AST_PH_RANGE: assert property (@(posedge clk_mst) disable iff (!rst_n)
    run |-> (ph < nticks)); // R6

  AST_FRM_ON_BIT_FALL: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (frm_clk != $past(frm_clk)) |-> (!bit_clk && $past(bit_clk))); // R7

endmodule

// File: rtl/audclk_master_gen.sv
module audclk_master_gen
  import audclk_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES    = 1024,
  parameter int unsigned BITS_PER_FRAME = FRAME_BITS
) (
  input  logic       clk_mst,
  input  logic       rst_n,
  input  logic       dat_pin_in,
  input  logic       frm_pin_in,
  input  logic       bit_pin_in,
  output logic       frm_out,
  output logic       frm_oe,
  output logic       bit_out,
  output logic       bit_oe,
  output logic       cfg_valid,
  output logic       cfg_master,
  output logic       cfg_double,
  output logic [9:0] cfg_ratio
);

  strap_t cfg;
  logic   done;
  logic   run;
  logic   tick;
  logic   pre;

  audclk_strap #(.WAIT_CYCLES(WAIT_CYCLES)) u_strap (
    .clk_mst    (clk_mst),
    .rst_n      (rst_n),
    .dat_pin_in (dat_pin_in),
    .frm_pin_in (frm_pin_in),
    .bit_pin_in (bit_pin_in),
    .cfg        (cfg),
    .done       (done)
  );

  assign run = done & (cfg.role == ROLE_MASTER);

  audclk_prediv u_prediv (
    .clk_mst (clk_mst),
    .rst_n   (rst_n),
    .run     (run),
    .dbl     (cfg.dbl),
    .tick    (tick),
    .pre     (pre)
  );

  audclk_frame_ctr #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_ctr (
    .clk_mst (clk_mst),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .pre     (pre),
    .dbl     (cfg.dbl),
    .wide    (cfg.wide),
    .bit_clk (bit_out),
    .frm_clk (frm_out)
  );

  assign frm_oe     = run;
  assign bit_oe     = run;
  assign cfg_valid  = done;
  assign cfg_master = run;
  assign cfg_double = run & cfg.dbl;
  assign cfg_ratio  = run ? ratio_of(cfg.dbl, cfg.wide) : 10'd0;

  AST_OE_MASTER: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (frm_oe || bit_oe) |-> (cfg_valid && cfg_master)); // R3

  AST_QUIET_UNDRIVEN: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !frm_oe |-> (!frm_out && !bit_out)); // R3

  AST_OE_STAYS: assert property (@(posedge clk_mst) disable iff (!rst_n)
    frm_oe |=> frm_oe); // R8

endmodule

// File: tb/audclk_master_gen_test.sv
module audclk_master_gen_test;

  localparam int unsigned WAIT = 1024;

  logic       clk_mst = 1'b0;
  logic       rst_n = 1'b0;
  logic       dat_pin_in = 1'b0;
  logic       frm_pin_in = 1'b0;
  logic       bit_pin_in = 1'b0;
  logic       frm_out, frm_oe, bit_out, bit_oe;
  logic       cfg_valid, cfg_master, cfg_double;
  logic [9:0] cfg_ratio;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk_mst = ~clk_mst;

  audclk_master_gen uut (
    .clk_mst(clk_mst), .rst_n(rst_n),
    .dat_pin_in(dat_pin_in), .frm_pin_in(frm_pin_in), .bit_pin_in(bit_pin_in),
    .frm_out(frm_out), .frm_oe(frm_oe), .bit_out(bit_out), .bit_oe(bit_oe),
    .cfg_valid(cfg_valid), .cfg_master(cfg_master), .cfg_double(cfg_double),
    .cfg_ratio(cfg_ratio)
  );

  function automatic int exp_ratio(bit m, bit d, bit w);
    int b;
    if (!m) return 0;
    b = w ? 384 : 256;
    return d ? b / 2 : b;
  endfunction

  function automatic bit exp_bit(int k, int mm);
    int p;
    p = k % mm;
    return (2 * p >= mm);
  endfunction

  function automatic bit exp_frm(int k, int mm);
    return ((k / mm) % 64) >= 32;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_case(input bit m, input bit d, input bit w);
    int mm, bad_b, bad_f, er;
    er = exp_ratio(m, d, w);
    mm = er / 64;
    @(negedge clk_mst);
    rst_n = 1'b0;
    dat_pin_in = m; frm_pin_in = d; bit_pin_in = w;
    repeat (3) @(negedge clk_mst);
    check("R1 valid in reset", cfg_valid, 0);
    check("R1 oe in reset", {frm_oe, bit_oe, frm_out, bit_out}, 0);
    check("R1 ratio in reset", cfg_ratio, 0);
    rst_n = 1'b1;
    repeat (WAIT - 1) @(posedge clk_mst);
    #1;
    check("R2 not yet captured", cfg_valid, 0);
    check("R2 no drive before capture", {frm_oe, bit_oe}, 0);
    @(posedge clk_mst);
    #1;
    check("R2 captured", cfg_valid, 1);
    check("R3 role", cfg_master, m);
    check("R3 enables", {frm_oe, bit_oe}, m ? 3 : 0);
    check("R4 speed", cfg_double, m & d);
    check("R5 ratio", cfg_ratio, er);
    bad_b = 0; bad_f = 0;
    for (int k = 0; k < (m ? 2 * 64 * mm : 400); k++) begin
      if (k == 37) begin
        dat_pin_in = 1'($urandom); frm_pin_in = 1'($urandom); bit_pin_in = 1'($urandom);
      end
      if (m) begin
        if (bit_out != exp_bit(k, mm)) bad_b++;
        if (frm_out != exp_frm(k, mm)) bad_f++;
      end else begin
        if (bit_out || frm_out || bit_oe || frm_oe) bad_b++;
      end
      @(posedge clk_mst);
      #1;
    end
    check(m ? "R6 bit clock wave" : "R3 slave quiet", bad_b, 0);
    if (m) check("R7 frame clock wave", bad_f, 0);
    check("R8 role held", cfg_master, m);
    check("R8 speed held", cfg_double, m & d);
    check("R8 ratio held", cfg_ratio, er);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    run_case(1'b1, 1'b0, 1'b0);
    run_case(1'b1, 1'b0, 1'b1);
    run_case(1'b1, 1'b1, 1'b0);
    run_case(1'b1, 1'b1, 1'b1);
    run_case(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      run_case(1'($urandom), 1'($urandom), 1'($urandom));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule